// File: doc/BRIEF.md
# Configuration Register Target on a Two-Wire Serial Bus

This block lets an external host controller read and write a small bank of eight 8-bit configuration registers over a two-wire serial bus (I2C framing). The block is the only target on its bus and answers to one fixed 7-bit address. SCL and SDA reach it as raw pin samples. It pulls SDA low through an open-drain enable and never drives the line high.

The host first writes a register pointer. It then either streams data bytes into consecutive registers, or issues a repeated start in read direction and clocks out consecutive registers until it declines a byte. The whole bank is visible at all times as a flat parallel output. A companion engine that restores settings from non-volatile storage can overwrite every register at once with a single-cycle strobe. The top bit of the last register is a status flag. Only that engine can set or clear it; the host can read it but cannot change it.

Top module: `cfg_i2c_target`

## Requirements
- R1: After reset, the register bytes at pointers 0 to 7 read A0, E1, 66, 48, 59, 70, 3D and 4B (hex). `regs_o[8*i+7:8*i]` carries register i. `sda_oe` is 0.
- R2: A first byte of {7'h21, rw} is acknowledged by driving SDA low in the ninth clock. Any other 7-bit address is not acknowledged. After a mismatch the block drives SDA for nothing and changes no register until the next start condition.
- R3: In a write, the byte after the address byte sets the register pointer. The next data byte, once acknowledged, is written to the register the pointer names.
- R4: Each further data byte in the same write is acknowledged and goes to the next register, because the pointer increments after every byte.
- R5: After a pointer write, a repeated start with rw=1 returns the register at the pointer, MSB first. Each byte the host acknowledges is followed by the next register. A host NAK ends the read.
- R6: For pointer values 8 to 255, the data bytes and the pointer byte are still acknowledged. Reads return FF and writes change no register.
- R7: Bit 7 of register 7 keeps its value on host writes. Bits 6:0 of register 7 take the written value.
- R8: While `load_strobe` is high at a clock edge, all 64 bits of `load_data` (register i in bits 8*i+7:8*i) replace the whole bank, status bit included. The new values show on `regs_o` after that edge.
- R9: `sda_oe` changes only while the synchronised SCL is low, except when a start or stop condition forces a release. After a stop, `sda_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw SCL pin sample |
| sda_i | input | 1 | Raw SDA pin sample (wired-AND bus level) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| load_strobe | input | 1 | One-cycle parallel load from the non-volatile copy engine |
| load_data | input | 64 | Image for the parallel load, register i in bits 8*i+7:8*i |
| regs_o | output | 64 | Current register contents, register i in bits 8*i+7:8*i |

## Verification
Single-byte writes separate correct pointer capture from write-path faults. Page writes that start at pointer 6 run through register 7 into the empty range, which exposes errors in pointer increment, bound checking and status-bit masking together. Reads of several bytes that end in a host NAK, and reads that begin beyond the bank, show whether the read pointer advances and whether the FF fill works. A wrong address followed by data bytes shows whether the ignore state stays silent. Seeded random sequences of write and read transfers, and a parallel load with the status bit set, are compared against a bench-side model of the bank.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_PTR,
        S_PTR_ACK,
        S_WDATA,
        S_WDATA_ACK,
        S_RDATA,
        S_RDATA_ACK,
        S_IGNORE
    } bus_state_e;

    typedef struct packed {
        bus_state_e st;
        logic [3:0] cnt;
        logic [7:0] sh;
        logic [7:0] tx;
        logic [7:0] ptr;
        logic       rw;
        logic       more;
        logic       oe;
    } fsm_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d          = q;
        d.scl_pipe = {q.scl_pipe[STAGES-2:0], scl_i};
        d.sda_pipe = {q.sda_pipe[STAGES-2:0], sda_i};
        d.scl_prev = q.scl_pipe[STAGES-1];
        d.sda_prev = q.sda_pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_s     = q.scl_pipe[STAGES-1];
    assign sda_s     = q.sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~q.scl_prev;
    assign scl_fall  = ~scl_s & q.scl_prev;
    assign start_det = scl_s & q.scl_prev & q.sda_prev & ~sda_s;
    assign stop_det  = scl_s & q.scl_prev & ~q.sda_prev & sda_s;
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
    import cfg_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h21
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [7:0] rd_data,
    output logic [7:0] rd_addr,
    output logic       wr_en,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data,
    output logic       sda_oe
);
    fsm_t d, q;

    always_comb begin
        d       = q;
        wr_en   = 1'b0;
        wr_addr = q.ptr;
        wr_data = q.sh;
        if (start_det) begin
            d.st  = S_ADDR;
            d.cnt = 4'd0;
            d.oe  = 1'b0;
        end else if (stop_det) begin
            d.st  = S_IDLE;
            d.cnt = 4'd0;
            d.oe  = 1'b0;
        end else begin
            case (q.st)
                S_ADDR, S_PTR, S_WDATA: begin
                    if (scl_rise && q.cnt < 4'd8) begin
                        d.sh  = {q.sh[6:0], sda_s};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        d.cnt = 4'd0;
                        if (q.st == S_ADDR) begin
                            if (q.sh[7:1] == DEV_ADDR) begin
                                d.oe = 1'b1;
                                d.rw = q.sh[0];
                                d.st = S_ADDR_ACK;
                            end else begin
                                d.st = S_IGNORE;
                            end
                        end else if (q.st == S_PTR) begin
                            d.ptr = q.sh;
                            d.oe  = 1'b1;
                            d.st  = S_PTR_ACK;
                        end else begin
                            wr_en = 1'b1;
                            d.ptr = q.ptr + 8'd1;
                            d.oe  = 1'b1;
                            d.st  = S_WDATA_ACK;
                        end
                    end
                end
                S_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (q.rw) begin
                            d.oe  = ~rd_data[7];
                            d.tx  = {rd_data[6:0], 1'b1};
                            d.cnt = 4'd1;
                            d.st  = S_RDATA;
                        end else begin
                            d.oe = 1'b0;
                            d.st = S_PTR;
                        end
                    end
                end
                S_PTR_ACK, S_WDATA_ACK: begin
                    if (scl_fall) begin
                        d.oe = 1'b0;
                        d.st = S_WDATA;
                    end
                end
                S_RDATA: begin
                    if (scl_fall) begin
                        if (q.cnt == 4'd8) begin
                            d.oe  = 1'b0;
                            d.cnt = 4'd0;
                            d.ptr = q.ptr + 8'd1;
                            d.st  = S_RDATA_ACK;
                        end else begin
                            d.oe  = ~q.tx[7];
                            d.tx  = {q.tx[6:0], 1'b1};
                            d.cnt = q.cnt + 4'd1;
                        end
                    end
                end
                S_RDATA_ACK: begin
                    if (scl_rise) begin
                        d.more = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.more) begin
                            d.oe  = ~rd_data[7];
                            d.tx  = {rd_data[6:0], 1'b1};
                            d.cnt = 4'd1;
                            d.st  = S_RDATA;
                        end else begin
                            d.st = S_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    assign rd_addr = q.ptr;
    assign sda_oe  = q.oe;
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank #(
    parameter int                  NREG        = 8,
    parameter logic [NREG*8-1:0]   RESET_IMAGE = 64'h4B3D_7059_4866_E1A0,
    parameter logic [NREG*8-1:0]   RO_MASK     = 64'h8000_0000_0000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [7:0]        rd_addr,
    output logic [7:0]        rd_data,
    input  logic              load_strobe,
    input  logic [NREG*8-1:0] load_data,
    output logic [NREG*8-1:0] regs_o
);
    localparam int         IDXW   = (NREG > 1) ? $clog2(NREG) : 1;
    localparam logic [7:0] NREG_B = 8'(NREG);

    logic [NREG-1:0][7:0] regs_d, regs_q;
    logic [NREG-1:0][7:0] ro_a;
    logic [IDXW-1:0]      widx, ridx;

    assign ro_a = RO_MASK;
    assign widx = wr_addr[IDXW-1:0];
    assign ridx = rd_addr[IDXW-1:0];

    always_comb begin
        regs_d = regs_q;
        if (load_strobe) begin
            regs_d = load_data;
        end else if (wr_en && wr_addr < NREG_B) begin
            regs_d[widx] = (wr_data & ~ro_a[widx]) | (regs_q[widx] & ro_a[widx]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= RESET_IMAGE;
        else        regs_q <= regs_d;
    end

    assign rd_data = (rd_addr < NREG_B) ? regs_q[ridx] : 8'hFF;
    assign regs_o  = regs_q;
endmodule

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target
    import cfg_i2c_pkg::*;
#(
    parameter logic [6:0]        DEV_ADDR    = 7'h21,
    parameter int                NREG        = 8,
    parameter int                SYNC_STAGES = 2,
    parameter logic [NREG*8-1:0] RESET_IMAGE = 64'h4B3D_7059_4866_E1A0,
    parameter logic [NREG*8-1:0] RO_MASK     = 64'h8000_0000_0000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              load_strobe,
    input  logic [NREG*8-1:0] load_data,
    output logic [NREG*8-1:0] regs_o
);
    localparam int REGW = NREG * 8;

    logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic       wr_en;
    logic [7:0] wr_addr, wr_data, rd_addr, rd_data;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_target_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sda_oe    (sda_oe)
    );

    cfg_regbank #(
        .NREG        (NREG),
        .RESET_IMAGE (RESET_IMAGE),
        .RO_MASK     (RO_MASK)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .load_strobe (load_strobe),
        .load_data   (load_data[REGW-1:0]),
        .regs_o      (regs_o)
    );
endmodule

// File: rtl/cfg_i2c_target_chk.sv
module cfg_i2c_target_chk #(
    parameter int REGW       = 64,
    parameter int STATUS_BIT = 63
) (
    input logic            clk,
    input logic            rst_n,
    input logic            scl_s,
    input logic            start_det,
    input logic            stop_det,
    input logic            sda_oe,
    input logic            wr_en,
    input logic            load_strobe,
    input logic [REGW-1:0] load_data,
    input logic [REGW-1:0] regs_o
);
    // R9: the open-drain enable moves only while SCL is low, or on start/stop
    p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> (!$past(scl_s) || $past(start_det) || $past(stop_det)));

    // R9: a stop condition releases the line
    p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R7: the status flag moves only through the parallel load
    p_status_ro_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load_strobe |=> $stable(regs_o[STATUS_BIT]));

    // R8: the parallel load replaces the whole bank in one edge
    p_load_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load_strobe |=> (regs_o == $past(load_data)));

    // R3: register contents change only after a write strobe or a load
    p_change_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_strobe && !wr_en) |=> $stable(regs_o));
endmodule

bind cfg_i2c_target cfg_i2c_target_chk #(
    .REGW       (REGW),
    .STATUS_BIT (REGW - 1)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_s       (scl_s),
    .start_det   (start_det),
    .stop_det    (stop_det),
    .sda_oe      (sda_oe),
    .wr_en       (wr_en),
    .load_strobe (load_strobe),
    .load_data   (load_data),
    .regs_o      (regs_o)
);

// File: tb/cfg_i2c_target_tb.sv
module cfg_i2c_target_tb;
    localparam int Q = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_scl = 1'b1;
    logic        host_sda = 1'b1;
    logic        sda_oe;
    logic        load_strobe = 1'b0;
    logic [63:0] load_data = '0;
    logic [63:0] regs_o;
    logic        sda_line;

    int errors = 0;
    int checks = 0;
    logic [7:0] model [8];
    logic [7:0] wbuf [16];

    assign sda_line = host_sda & ~sda_oe;

    always #2.5 clk = ~clk;

    cfg_i2c_target u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (host_scl),
        .sda_i       (sda_line),
        .sda_oe      (sda_oe),
        .load_strobe (load_strobe),
        .load_data   (load_data),
        .regs_o      (regs_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] model_flat();
        logic [63:0] f;
        for (int i = 0; i < 8; i++) f[8*i +: 8] = model[i];
        return f;
    endfunction

    function automatic logic [7:0] model_read(input logic [7:0] p);
        return (p < 8'd8) ? model[p[2:0]] : 8'hFF;
    endfunction

    function automatic string tag_of(input logic [7:0] p);
        if (p >= 8'd8) return "R6";
        if (p == 8'd7) return "R7";
        return "R4";
    endfunction

    task automatic model_write(input logic [7:0] p, input logic [7:0] v);
        if (p == 8'd7)     model[7] = {model[7][7], v[6:0]};
        else if (p < 8'd8) model[p[2:0]] = v;
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        host_sda = 1'b1; wq();
        host_scl = 1'b1; wq();
        host_sda = 1'b0; wq();
        host_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        host_sda = 1'b0; wq();
        host_scl = 1'b1; wq();
        host_sda = 1'b1; wq(); wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            host_sda = b[i]; wq();
            host_scl = 1'b1; wq(); wq();
            host_scl = 1'b0; wq();
        end
        host_sda = 1'b1; wq();
        host_scl = 1'b1; wq();
        ack = sda_line; wq();
        host_scl = 1'b0; wq();
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        host_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq();
            host_scl = 1'b1; wq();
            b[i] = sda_line; wq();
            host_scl = 1'b0;
        end
        wq();
        host_sda = give_ack ? 1'b0 : 1'b1; wq();
        host_scl = 1'b1; wq(); wq();
        host_scl = 1'b0; wq();
        host_sda = 1'b1;
    endtask

    task automatic do_write(input logic [6:0] dev, input logic [7:0] ptr, input int n);
        logic a;
        logic [7:0] p;
        bus_start();
        send_byte({dev, 1'b0}, a);
        if (dev != 7'h21) begin
            check("R2 mismatch NAK", a, 1'b1);
            send_byte(ptr, a);
            check("R2 silent after NAK", a, 1'b1);
            send_byte(wbuf[0], a);
            check("R2 silent after NAK", a, 1'b1);
            bus_stop();
            check("R2 bank untouched", regs_o, model_flat());
            return;
        end
        check("R2 address ACK", a, 1'b0);
        send_byte(ptr, a);
        check((ptr >= 8'd8) ? "R6 pointer ACK" : "R3 pointer ACK", a, 1'b0);
        p = ptr;
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], a);
            check(i == 0 ? "R3 data ACK" : "R4 data ACK", a, 1'b0);
            model_write(p, wbuf[i]);
            p = p + 8'd1;
        end
        bus_stop();
        check("R9 released after stop", sda_oe, 1'b0);
        check(tag_of(ptr), regs_o, model_flat());
    endtask

    task automatic do_read(input logic [7:0] ptr, input int n);
        logic a;
        logic [7:0] b;
        logic [7:0] p;
        bus_start();
        send_byte({7'h21, 1'b0}, a);
        check("R2 address ACK", a, 1'b0);
        send_byte(ptr, a);
        check("R5 pointer ACK", a, 1'b0);
        bus_start();
        send_byte({7'h21, 1'b1}, a);
        check("R5 read address ACK", a, 1'b0);
        p = ptr;
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, b);
            check((p >= 8'd8) ? "R6 read fill" : "R5 read data", b, model_read(p));
            p = p + 8'd1;
        end
        bus_stop();
        check("R9 released after stop", sda_oe, 1'b0);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        model[0] = 8'hA0; model[1] = 8'hE1; model[2] = 8'h66; model[3] = 8'h48;
        model[4] = 8'h59; model[5] = 8'h70; model[6] = 8'h3D; model[7] = 8'h4B;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 reset image", regs_o, 64'h4B3D_7059_4866_E1A0);
        check("R1 line released", sda_oe, 1'b0);
        do_read(8'd0, 8);

        // R3 single byte write, then read back
        wbuf[0] = 8'h5A;
        do_write(7'h21, 8'd2, 1);
        do_read(8'd2, 1);

        // R4 page write across the bank
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        do_write(7'h21, 8'd0, 4);

        // R7 and R6: write from 6 through the status register into empty space
        wbuf[0] = 8'hC3; wbuf[1] = 8'hFF; wbuf[2] = 8'h99; wbuf[3] = 8'h77;
        do_write(7'h21, 8'd6, 4);
        check("R7 status bit kept", regs_o[63], 1'b0);
        check("R7 low bits written", regs_o[62:56], 7'h7F);
        do_read(8'd5, 5);
        do_read(8'h10, 2);

        // R2 wrong address is ignored
        wbuf[0] = 8'h00;
        do_write(7'h22, 8'd1, 1);
        do_write(7'h50, 8'd3, 1);

        // R8 parallel load with status flag set
        @(negedge clk);
        load_data   = {8'hCB, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07};
        load_strobe = 1'b1;
        @(negedge clk);
        load_strobe = 1'b0;
        check("R8 load image", regs_o, {8'hCB, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07});
        for (int i = 0; i < 8; i++) model[i] = load_data[8*i +: 8];
        do_read(8'd7, 1);
        wbuf[0] = 8'h00;
        do_write(7'h21, 8'd7, 1);
        check("R7 status survives host write", regs_o[63], 1'b1);

        // random mix of transfers
        for (int t = 0; t < 24; t++) begin
            logic [7:0] p;
            int n;
            p = 8'($urandom_range(0, 9));
            n = $urandom_range(1, 4);
            if ($urandom_range(0, 1) == 0) begin
                for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
                do_write(7'h21, p, n);
            end else begin
                do_read(p, n);
            end
        end
        check("R5 final bank", regs_o, model_flat());

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule